// File: doc/BRIEF.md
# GPIO Event and Task Channel Unit

This unit sits between a bank of general-purpose pins and an on-chip event-to-task routing fabric. It lets pin activity raise events and lets events from elsewhere in the chip drive pin levels, with no processor involvement. Eight event channels each watch one selectable pin. They emit single-cycle pulses on a rising edge, on a falling edge and on either edge. Eight task channels each accept three action pulses (drive high, drive low, invert). Each action applies to every pin bound to that channel.

Software sets the block up through a simple word-wide register port. Each event channel has one register holding a pin select and an enable. Pin bindings to task channels are packed one byte per pin, four pins per word. To retarget an event channel, software first clears its enable, then writes the new select, then sets the enable again. The block keeps that sequence free of spurious events.

Top module: `gpio_evt_task_unit`

## Requirements
- R1: After reset every configuration field reads zero, `pin_out` is all zero and no event pulse is asserted.
- R2: For an enabled event channel C, a low-to-high change on its selected pin asserts `evt_pulse[C]` for exactly one cycle, on the third rising clock edge after the change is first sampled.
- R3: A high-to-low change on the selected pin of an enabled channel C asserts `evt_pulse[8+C]` for exactly one cycle, with the same timing as R2.
- R4: Every change on the selected pin of an enabled channel C asserts `evt_pulse[16+C]` for one cycle, together with the matching R2 or R3 pulse.
- R5: A channel whose enable bit is zero asserts none of its three event pulses, whatever its pin does.
- R6: Clearing the enable, writing a new pin select and setting the enable again in three writes produces no event unless the newly selected pin actually changes.
- R7: For a pin bound to task channel C, a pulse on `task_pulse[C]` sets it, `task_pulse[8+C]` clears it and `task_pulse[16+C]` inverts it, on the clock edge at which the pulse is sampled.
- R8: When several actions reach one pin in the same cycle, clear beats set and set beats invert.
- R9: Pin p is bound by word 16 + p/4 at bits [8(p mod 4)+3 : 8(p mod 4)]. Bit 0 of that field enables the binding and bits 3:1 give the channel. A pin with its enable bit at zero keeps its level.
- R10: Event channel C's register sits at word address C, with the pin select in bits [3:0] and the enable in bit 31. All registers read back the written value with unused bits (event bits 30:4, binding bits 7:4 of each byte) as zero.
- R11: All pins bound to the same task channel act together on one task pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| pin_in | input | 16 | Pin input levels, asynchronous to `clk` |
| pin_out | output | 16 | Registered pin output levels |
| evt_pulse | output | 24 | Event pulses: [7:0] rising, [15:8] falling, [23:16] any edge |
| task_pulse | input | 24 | Task pulses: [7:0] set, [15:8] clear, [23:16] invert |

## Verification
Event results are due three rising edges after a pin change is first sampled. Two edges go to the synchronizer and one to the edge register. Task results and register writes take effect one edge after they are sampled, and a read returns data within the same cycle. The bench drives all stimulus at the falling edge. Its model keeps a three-deep history of the pin vector, so it predicts each event vector from the samples two and three edges back. It then compares every output at the falling edge that follows each rising edge.

// File: rtl/gpio_et_pkg.sv
`timescale 1ns/1ps
package gpio_et_pkg;
   // Per-pin task binding, laid out as the low nibble of its byte.
   typedef struct packed {
      logic [2:0] chan;
      logic       en;
   } pin_bind_t;

   localparam int BIND_BITS    = 4;
   localparam int PINS_PER_WORD = 4;
   localparam int EVT_EN_BIT   = 31;
endpackage

// File: rtl/gpio_et_sync.sv
`timescale 1ns/1ps
module gpio_et_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_et_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_et_evt_chan.sv
`timescale 1ns/1ps
module gpio_et_evt_chan #(
   parameter int NUM_PINS = 16,
   parameter int PIN_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [PIN_W-1:0]    sel,
   input  logic [NUM_PINS-1:0] pins_s,
   output logic                rise_o,
   output logic                fall_o,
   output logic                any_o
);
   logic cur, last_q, rise_q, fall_q, any_q;

   // Out-of-range selects watch a constant low.
   assign cur = (int'(sel) < NUM_PINS) ? pins_s[sel] : 1'b0;

   // last_q tracks the selected pin even while disabled, so re-enabling
   // after a new select compares against the new pin's own level.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         any_q  <= 1'b0;
      end else begin
         last_q <= cur;
         rise_q <= en & cur & ~last_q;
         fall_q <= en & ~cur & last_q;
         any_q  <= en & (cur ^ last_q);
      end
   end

   assign rise_o = rise_q;
   assign fall_o = fall_q;
   assign any_o  = any_q;

   a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q |=> !rise_q);
   a_r3_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      fall_q |=> !fall_q);
   a_r4_any_pairs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      any_q |-> (rise_q ^ fall_q));
   a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> !(rise_q || fall_q || any_q));
endmodule

// File: rtl/gpio_et_task_pin.sv
`timescale 1ns/1ps
module gpio_et_task_pin
   import gpio_et_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pin_bind_t         bind_i,
   input  logic [NUM_CH-1:0] set_i,
   input  logic [NUM_CH-1:0] clr_i,
   input  logic [NUM_CH-1:0] tog_i,
   output logic              pin_o
);
   logic ch_ok, hit_set, hit_clr, hit_tog, pin_q;

   assign ch_ok   = bind_i.en && (int'(bind_i.chan) < NUM_CH);
   assign hit_set = ch_ok && set_i[bind_i.chan];
   assign hit_clr = ch_ok && clr_i[bind_i.chan];
   assign hit_tog = ch_ok && tog_i[bind_i.chan];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pin_q <= 1'b0;
      else if (hit_clr) pin_q <= 1'b0;
      else if (hit_set) pin_q <= 1'b1;
      else if (hit_tog) pin_q <= ~pin_q;
   end

   assign pin_o = pin_q;

   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (bind_i.en && clr_i[bind_i.chan]) |=> !pin_q);
   a_r8_set_over_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (bind_i.en && set_i[bind_i.chan] && !clr_i[bind_i.chan]) |=> pin_q);
   a_r7_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (bind_i.en && tog_i[bind_i.chan] && !set_i[bind_i.chan] && !clr_i[bind_i.chan])
      |=> (pin_q != $past(pin_q)));
   a_r9_unbound_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bind_i.en |=> $stable(pin_q));
endmodule

// File: rtl/gpio_evt_task_unit.sv
`timescale 1ns/1ps
module gpio_evt_task_unit
   import gpio_et_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int NUM_CH      = 8,
   parameter int ADDR_W      = 6,
   parameter int TASK_BASE   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [ADDR_W-1:0]     cfg_addr,
   input  logic [31:0]           cfg_wdata,
   output logic [31:0]           cfg_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [3*NUM_CH-1:0]   evt_pulse,
   input  logic [3*NUM_CH-1:0]   task_pulse
);
   localparam int PIN_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
   localparam int BIND_WORDS = NUM_PINS / PINS_PER_WORD;

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("gpio_evt_task_unit: NUM_CH must be 1..8 (3-bit channel field)");
   end
   if (NUM_PINS % PINS_PER_WORD != 0) begin : g_bad_pins
      $error("gpio_evt_task_unit: NUM_PINS must be a multiple of 4");
   end
   if (NUM_CH > TASK_BASE || TASK_BASE + BIND_WORDS > (1 << ADDR_W)) begin : g_bad_map
      $error("gpio_evt_task_unit: register map does not fit ADDR_W");
   end
   if (PIN_W > EVT_EN_BIT) begin : g_bad_sel
      $error("gpio_evt_task_unit: pin select overlaps enable bit");
   end

   logic [NUM_CH-1:0]             ev_en_q;
   logic [NUM_CH-1:0][PIN_W-1:0]  ev_sel_q;
   pin_bind_t [NUM_PINS-1:0]      bind_q;
   logic [NUM_PINS-1:0]           pins_s;

   // Configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_en_q  <= '0;
         ev_sel_q <= '0;
         bind_q   <= '0;
      end else if (cfg_we) begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (int'(cfg_addr) == c) begin
               ev_sel_q[c] <= cfg_wdata[PIN_W-1:0];
               ev_en_q[c]  <= cfg_wdata[EVT_EN_BIT];
            end
         end
         for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(cfg_addr) == TASK_BASE + p / PINS_PER_WORD)
               bind_q[p] <= cfg_wdata[8*(p % PINS_PER_WORD) +: BIND_BITS];
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (int'(cfg_addr) == c) begin
            cfg_rdata[PIN_W-1:0]   = ev_sel_q[c];
            cfg_rdata[EVT_EN_BIT]  = ev_en_q[c];
         end
      end
      for (int p = 0; p < NUM_PINS; p++) begin
         if (int'(cfg_addr) == TASK_BASE + p / PINS_PER_WORD)
            cfg_rdata[8*(p % PINS_PER_WORD) +: BIND_BITS] = bind_q[p];
      end
   end

   gpio_et_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pins_s)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_evt
      gpio_et_evt_chan #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) i_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (ev_en_q[c]),
         .sel    (ev_sel_q[c]),
         .pins_s (pins_s),
         .rise_o (evt_pulse[c]),
         .fall_o (evt_pulse[NUM_CH + c]),
         .any_o  (evt_pulse[2*NUM_CH + c])
      );
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      gpio_et_task_pin #(.NUM_CH(NUM_CH)) i_pin (
         .clk    (clk),
         .rst_n  (rst_n),
         .bind_i (bind_q[p]),
         .set_i  (task_pulse[NUM_CH-1:0]),
         .clr_i  (task_pulse[2*NUM_CH-1:NUM_CH]),
         .tog_i  (task_pulse[3*NUM_CH-1:2*NUM_CH]),
         .pin_o  (pin_out[p])
      );
   end

   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_out == '0));
   a_r10_unused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_addr) < NUM_CH) |-> (cfg_rdata[EVT_EN_BIT-1:PIN_W] == '0));
endmodule

// File: tb/test_gpio_evt_task_unit.sv
`timescale 1ns/1ps
module test_gpio_evt_task_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out;
   logic [23:0] evt_pulse;
   logic [23:0] task_pulse = '0;

   always #2.5 clk = ~clk;

   gpio_evt_task_unit i_gpio_evt_task_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .evt_pulse(evt_pulse), .task_pulse(task_pulse)
   );

   int n_vec = 0, n_fail = 0;
   string cur_req = "R1";

   // Bench-side mirror of configuration and expected state.
   logic [3:0]  m_bind [16];
   logic        m_en   [8];
   logic [3:0]  m_sel  [8];
   logic [15:0] h1 = '0, h2 = '0, h3 = '0;
   logic [15:0] exp_out = '0;
   logic        pw = 1'b0;
   logic [5:0]  pa;
   logic [31:0] pd;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(int a);
      logic [31:0] r = '0;
      if (a < 8) begin
         r[3:0] = m_sel[a];
         r[31]  = m_en[a];
      end else if (a >= 16 && a < 20) begin
         for (int b = 0; b < 4; b++) r[8*b +: 4] = m_bind[(a-16)*4 + b];
      end
      return r;
   endfunction

   function automatic logic [15:0] next_out(logic [15:0] cur, logic [23:0] tp);
      logic [15:0] n = cur;
      for (int p = 0; p < 16; p++) begin
         if (m_bind[p][0]) begin
            int c = int'(m_bind[p][3:1]);
            if (tp[8+c])       n[p] = 1'b0;
            else if (tp[c])    n[p] = 1'b1;
            else if (tp[16+c]) n[p] = ~cur[p];
         end
      end
      return n;
   endfunction

   function automatic logic [23:0] next_evt();
      logic [23:0] e = '0;
      for (int c = 0; c < 8; c++) begin
         logic a = h2[m_sel[c]];
         logic b = h3[m_sel[c]];
         if (m_en[c]) begin
            e[c]    = a & ~b;
            e[8+c]  = ~a & b;
            e[16+c] = a ^ b;
         end
      end
      return e;
   endfunction

   task automatic cycle();
      logic [15:0] n_out = next_out(exp_out, task_pulse);
      logic [23:0] n_evt = next_evt();
      @(posedge clk);
      @(negedge clk);
      exp_out = n_out;
      check(cur_req, {16'h0, pin_out}, {16'h0, exp_out});
      check(cur_req, {8'h0, evt_pulse}, {8'h0, n_evt});
      h3 = h2; h2 = h1; h1 = pin_in;
      if (pw) begin
         if (pa < 8) begin
            m_sel[pa] = pd[3:0];
            m_en[pa]  = pd[31];
         end else if (pa >= 16 && pa < 20) begin
            for (int b = 0; b < 4; b++) m_bind[(pa-16)*4 + b] = pd[8*b +: 4];
         end
         pw = 1'b0;
      end
      cfg_we = 1'b0;
   endtask

   task automatic wr(int a, logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
      pw = 1'b1; pa = 6'(a); pd = d;
      cycle();
   endtask

   task automatic rd(int a, string req);
      cfg_addr = 6'(a);
      #0.5;
      check(req, cfg_rdata, exp_rd(a));
   endtask

   task automatic pulse(logic [23:0] tp);
      task_pulse = tp;
      cycle();
      task_pulse = '0;
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0419));
      for (int i = 0; i < 16; i++) m_bind[i] = '0;
      for (int i = 0; i < 8; i++) begin m_en[i] = 1'b0; m_sel[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1", {16'h0, pin_out}, 32'h0);
      check("R1", {8'h0, evt_pulse}, 32'h0);
      for (int a = 0; a < 8; a++) rd(a, "R1");
      for (int a = 16; a < 20; a++) rd(a, "R1");

      // R9/R10 bindings: pin p -> channel p%8, pins 3 and 12 disabled
      cur_req = "R9";
      for (int w = 0; w < 4; w++) begin
         logic [31:0] d = '0;
         for (int b = 0; b < 4; b++) begin
            int p = w*4 + b;
            logic en = !(p == 3 || p == 12);
            d[8*b +: 8] = {4'hA, 3'(p % 8), en};  // upper nibble must read back 0
         end
         wr(16 + w, d);
      end
      for (int a = 16; a < 20; a++) rd(a, "R10");

      // Event channels: ch c watches pin 2c, ch7 disabled
      cur_req = "R10";
      for (int c = 0; c < 8; c++)
         wr(c, {(c != 7), 15'h7FFF, 12'h0, 4'(2*c)});
      for (int a = 0; a < 8; a++) rd(a, "R10");

      // R2/R3/R4 directed edges on ch0 (pin 0)
      cur_req = "R2 R3 R4";
      pin_in[0] = 1'b1;
      repeat (5) cycle();
      pin_in[0] = 1'b0;
      repeat (5) cycle();
      pin_in[4] = 1'b1; cycle(); pin_in[4] = 1'b0;
      repeat (5) cycle();

      // R8 priority on channel 0 (pins 0 and 8)
      cur_req = "R8";
      pulse(24'h010101);
      pulse(24'h010001);
      pulse(24'h010100);
      pulse(24'h010000);
      pulse(24'h000101);

      // R9/R11 channel 3 drives pin 11, pin 3 unbound
      cur_req = "R9 R11";
      pulse(24'h080000);
      pulse(24'h000008);
      pulse(24'h080000);

      // R6 reselect ch1 from pin 2 (low) to pin 9 (high)
      cur_req = "R6";
      pin_in[2] = 1'b0; pin_in[9] = 1'b1;
      repeat (4) cycle();
      wr(1, 32'h0000_0002);
      wr(1, 32'h0000_0009);
      wr(1, 32'h8000_0009);
      repeat (6) cycle();

      // R5 disabled ch7 on pin 14
      cur_req = "R5";
      for (int i = 0; i < 6; i++) begin
         pin_in[14] = ~pin_in[14];
         repeat (4) cycle();
      end

      // Random traffic
      cur_req = "R7 R11";
      for (int i = 0; i < 3000; i++) begin
         pin_in     = 16'($urandom);
         task_pulse = 24'($urandom & $urandom & $urandom);
         if (($urandom % 40) == 0) begin
            logic [31:0] d = $urandom;
            wr(16 + int'($urandom % 4), d);
         end else begin
            cycle();
         end
      end
      task_pulse = '0;
      for (int a = 16; a < 20; a++) rd(a, "R10");

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule